// File: doc/BRIEF.md
# Halfword-Swapping DMA Memory Bridge

This block sits between a peripheral that moves data sixteen bits at a time and a byte-addressed memory port. A transfer request carries a direction, a start address, a byte count and a swap flag. The bridge merges a base value into the address with a bitwise OR, so the base supplies the high bits and the peripheral supplies the low bits. It then issues one or more memory commands and streams halfwords between the two sides, one halfword per beat, with a valid/ready handshake on each stream.

In swap mode the bridge works in whole halfwords. The low bit of the merged address and the low bit of the byte count are cleared before anything is issued. Each halfword has its two bytes exchanged, whichever way the data flows. In this mode a transfer towards memory is split into commands of at most `CHUNK_BYTES` bytes, and the address advances by each chunk's length. Reads, and pass-through transfers in either direction, go out as a single command. In pass-through mode the address, the count and the data are used exactly as given. When the count is odd, the last beat carries one meaningful byte.

A request whose count is zero after rounding issues no memory command. A one-cycle completion strobe ends every request.

Top module: `halfswap_dma_bridge`

## Requirements
- R1: Every memory command address is the request address bitwise-ORed with `base_addr`, with no rounding in pass-through mode (`req_swap`=0).
- R2: With `req_swap`=1, bit 0 of the merged address and bit 0 of the byte count are cleared before the first command.
- R3: With `req_swap`=1 on a memory write (`req_write`=1), `mem_wdata` equals `per_in_data` with bits [15:8] and [7:0] exchanged.
- R4: With `req_swap`=1 on a memory read (`req_write`=0), `per_out_data` equals `mem_rdata` with bits [15:8] and [7:0] exchanged.
- R5: In pass-through mode, data passes unchanged in both directions, and a request of N bytes moves ceil(N/2) beats.
- R6: A swap-mode memory write is issued as commands of `CHUNK_BYTES` (default 64) bytes, with a shorter last command for the remainder. Each command starts at the previous command's address plus its length.
- R7: Memory reads, and pass-through writes, are issued as one command covering the whole count.
- R8: A request whose count is zero after rounding issues no memory command and moves no beat. Its `done` pulse comes in the cycle after the request is accepted.
- R9: `done` is high for exactly one cycle, in the cycle after the request's last data beat.
- R10: After reset, and while idle, `req_ready` is 1 and `mem_cmd_valid`, `mem_wvalid`, `per_out_valid` and `done` are 0. A reset in the middle of a transfer returns the bridge to this idle state.
- R11: While `mem_cmd_valid` is high and `mem_cmd_ready` is low, the command stays valid and its address and length hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_addr | input | AW | Base value ORed into every request address |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge idle and taking a request |
| req_write | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| req_swap | input | 1 | 1: halfword mode with byte exchange |
| req_addr | input | AW | Request start address |
| req_len | input | LW | Request byte count |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_write | output | 1 | Command direction |
| mem_cmd_addr | output | AW | Command byte address |
| mem_cmd_len | output | LW | Command byte count |
| per_in_valid | input | 1 | Peripheral halfword available |
| per_in_ready | output | 1 | Halfword taken from the peripheral |
| per_in_data | input | 16 | Halfword from the peripheral |
| mem_wvalid | output | 1 | Write halfword valid |
| mem_wready | input | 1 | Memory takes the write halfword |
| mem_wdata | output | 16 | Write halfword to memory |
| mem_rvalid | input | 1 | Read halfword valid |
| mem_rready | output | 1 | Bridge takes the read halfword |
| mem_rdata | input | 16 | Read halfword from memory |
| per_out_valid | output | 1 | Halfword to the peripheral valid |
| per_out_ready | input | 1 | Peripheral takes the halfword |
| per_out_data | output | 16 | Halfword to the peripheral |
| done | output | 1 | One-cycle completion strobe |

## Verification
On every cycle the assertions check the following: swap-mode commands are even in both address and length, swap-mode write commands never exceed the chunk size, a stalled command holds steady, the write data lanes are exchanged in swap mode, `done` never lasts two cycles, and nothing moves while the bridge is idle. Other behaviour can only be shown by the bench's scenarios, which compare against values the bench computes itself. That covers the OR-merged address, the chunk-to-chunk address advance, the number of commands and beats per request, the completion timing relative to the last beat, the zero-length case, and recovery from a reset in mid-transfer.

// File: rtl/dmab_pkg.sv
// Shared types for the halfword-swapping DMA bridge.
package dmab_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } dmab_state_e;
endpackage

// File: rtl/dmab_addr_form.sv
// Forms the effective address and count of a request.
// The base value is merged into the request address by bitwise OR. In swap mode,
// bit 0 of both the address and the count is cleared.
// Assumes: purely combinational; the caller latches the results on acceptance.
module dmab_addr_form #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic [AW-1:0] req_addr,
    input  logic [AW-1:0] base_addr,
    input  logic [LW-1:0] req_len,
    input  logic          swap,
    output logic [AW-1:0] eff_addr,
    output logic [LW-1:0] eff_len,
    output logic          eff_zero
);
    logic [AW-1:0] merged;

    // Merge the base, then apply halfword rounding when swapping.
    always_comb begin
        merged   = req_addr | base_addr;
        eff_addr = {merged[AW-1:1], merged[0] & ~swap};
        eff_len  = {req_len[LW-1:1], req_len[0] & ~swap};
        eff_zero = (eff_len == '0);
    end
endmodule

// File: rtl/dmab_lane_swap.sv
// Byte lane steering for one data word.
// When swap is set, the byte order of the word is reversed; for two bytes this
// exchanges the halves. Otherwise the word passes through unchanged.
// Assumes: combinational; swap is stable for the whole transfer.
module dmab_lane_swap #(
    parameter int BYTES = 2,
    localparam int W = 8 * BYTES
) (
    input  logic         swap,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // One steering mux per byte position.
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign dout[8*g +: 8] = swap ? din[8*(BYTES-1-g) +: 8] : din[8*g +: 8];
    end
endmodule

// File: rtl/dmab_seq.sv
// Transfer sequencer: takes a request, issues memory commands, counts beats and
// signals completion.
// Swap-mode writes are split into chunks of CHUNK_BYTES bytes; every other
// transfer is issued as one command.
// Assumes: CHUNK_BYTES is even and fits in LW bits; the caller reports each data
// handshake on beat_fire.
module dmab_seq
    import dmab_pkg::*;
#(
    parameter int AW          = 32,
    parameter int LW          = 16,
    parameter int CHUNK_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_swap,
    input  logic [AW-1:0] eff_addr,
    input  logic [LW-1:0] eff_len,
    input  logic          eff_zero,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic          cmd_write,
    output logic [AW-1:0] cmd_addr,
    output logic [LW-1:0] cmd_len,
    output logic          act_w,
    output logic          act_r,
    input  logic          beat_fire,
    output logic          swap_act,
    output logic          done
);
    localparam logic [LW-1:0] CHUNK_L = LW'(CHUNK_BYTES);

    dmab_state_e   state;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] rem_q;
    logic [LW-1:0] chunk_q;
    logic [LW-1:0] beats_q;
    logic          write_q;
    logic          swap_q;
    logic [LW:0]   beats_rnd;

    // Length of the command now offered: chunked only for swap-mode writes.
    always_comb begin
        cmd_len   = (write_q && swap_q && (rem_q > CHUNK_L)) ? CHUNK_L : rem_q;
        beats_rnd = {1'b0, cmd_len} + 1'b1;
    end

    // Decode the state into handshake and status outputs.
    always_comb begin
        req_ready = (state == ST_IDLE);
        cmd_valid = (state == ST_CMD);
        cmd_write = write_q;
        cmd_addr  = addr_q;
        act_w     = (state == ST_DATA) && write_q;
        act_r     = (state == ST_DATA) && !write_q;
        swap_act  = swap_q;
        done      = (state == ST_DONE);
    end

    // State machine with its position, remainder and beat counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
            chunk_q <= '0;
            beats_q <= '0;
            write_q <= 1'b0;
            swap_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    addr_q  <= eff_addr;
                    rem_q   <= eff_len;
                    write_q <= req_write;
                    swap_q  <= req_swap;
                    state   <= eff_zero ? ST_DONE : ST_CMD;
                end
                ST_CMD: if (cmd_ready) begin
                    chunk_q <= cmd_len;
                    beats_q <= beats_rnd[LW:1];
                    state   <= ST_DATA;
                end
                ST_DATA: if (beat_fire) begin
                    beats_q <= beats_q - 1'b1;
                    if (beats_q == LW'(1)) begin
                        rem_q  <= rem_q - chunk_q;
                        addr_q <= addr_q + AW'(chunk_q);
                        state  <= (rem_q == chunk_q) ? ST_DONE : ST_CMD;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/halfswap_dma_bridge.sv
// Top level of the halfword-swapping DMA bridge.
// Wires together address formation, the transfer sequencer and two byte-lane
// steering stages, one for each data direction. The data streams pass through
// combinationally, gated by the sequencer's active-direction flags.
// Assumes: one request is in flight at a time; the memory returns read data in
// order for each command.
module halfswap_dma_bridge #(
    parameter int AW          = 32,
    parameter int LW          = 16,
    parameter int CHUNK_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_addr,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_swap,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    output logic          mem_cmd_valid,
    input  logic          mem_cmd_ready,
    output logic          mem_cmd_write,
    output logic [AW-1:0] mem_cmd_addr,
    output logic [LW-1:0] mem_cmd_len,
    input  logic          per_in_valid,
    output logic          per_in_ready,
    input  logic [15:0]   per_in_data,
    output logic          mem_wvalid,
    input  logic          mem_wready,
    output logic [15:0]   mem_wdata,
    input  logic          mem_rvalid,
    output logic          mem_rready,
    input  logic [15:0]   mem_rdata,
    output logic          per_out_valid,
    input  logic          per_out_ready,
    output logic [15:0]   per_out_data,
    output logic          done
);
    logic [AW-1:0] eff_addr;
    logic [LW-1:0] eff_len;
    logic          eff_zero;
    logic          act_w;
    logic          act_r;
    logic          swap_act;
    logic          beat_fire;

    dmab_addr_form #(.AW(AW), .LW(LW)) u_form (
        .req_addr (req_addr),
        .base_addr(base_addr),
        .req_len  (req_len),
        .swap     (req_swap),
        .eff_addr (eff_addr),
        .eff_len  (eff_len),
        .eff_zero (eff_zero)
    );

    dmab_seq #(.AW(AW), .LW(LW), .CHUNK_BYTES(CHUNK_BYTES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_write(req_write),
        .req_swap (req_swap),
        .eff_addr (eff_addr),
        .eff_len  (eff_len),
        .eff_zero (eff_zero),
        .cmd_valid(mem_cmd_valid),
        .cmd_ready(mem_cmd_ready),
        .cmd_write(mem_cmd_write),
        .cmd_addr (mem_cmd_addr),
        .cmd_len  (mem_cmd_len),
        .act_w    (act_w),
        .act_r    (act_r),
        .beat_fire(beat_fire),
        .swap_act (swap_act),
        .done     (done)
    );

    // Gate the two data streams with the active direction and report beats.
    always_comb begin
        mem_wvalid    = act_w && per_in_valid;
        per_in_ready  = act_w && mem_wready;
        per_out_valid = act_r && mem_rvalid;
        mem_rready    = act_r && per_out_ready;
        beat_fire     = (act_w && per_in_valid && mem_wready) ||
                        (act_r && mem_rvalid && per_out_ready);
    end

    dmab_lane_swap #(.BYTES(2)) u_wlane (
        .swap(swap_act),
        .din (per_in_data),
        .dout(mem_wdata)
    );

    dmab_lane_swap #(.BYTES(2)) u_rlane (
        .swap(swap_act),
        .din (mem_rdata),
        .dout(per_out_data)
    );
endmodule

// File: rtl/dmab_checker.sv
// Protocol checker for the bridge, attached to the top level with bind.
// Assumes: sees the top-level ports and the latched swap flag.
module dmab_checker #(
    parameter int AW          = 32,
    parameter int LW          = 16,
    parameter int CHUNK_BYTES = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          mem_cmd_valid,
    input logic          mem_cmd_ready,
    input logic          mem_cmd_write,
    input logic [AW-1:0] mem_cmd_addr,
    input logic [LW-1:0] mem_cmd_len,
    input logic          mem_wvalid,
    input logic [15:0]   mem_wdata,
    input logic [15:0]   per_in_data,
    input logic          per_out_valid,
    input logic          swap_act,
    input logic          done
);
    // R2: swap-mode commands are halfword aligned in address and length.
    p_even_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid && swap_act |-> !mem_cmd_addr[0] && !mem_cmd_len[0]);

    // R3: the write lanes are exchanged in swap mode.
    p_write_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid && swap_act |-> mem_wdata == {per_in_data[7:0], per_in_data[15:8]});

    // R6: swap-mode write commands stay within the chunk size.
    p_chunk_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid && mem_cmd_write && swap_act |-> mem_cmd_len <= LW'(CHUNK_BYTES));

    // R8: no command is ever issued for zero bytes.
    p_nonzero_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |-> mem_cmd_len != '0);

    // R9: the completion strobe lasts a single cycle.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: an idle bridge drives no command, no data and no strobe.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_cmd_valid && !mem_wvalid && !per_out_valid && !done);

    // R11: a stalled command holds steady.
    p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid && !mem_cmd_ready |=>
            mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_len));
endmodule

bind halfswap_dma_bridge dmab_checker #(
    .AW(AW), .LW(LW), .CHUNK_BYTES(CHUNK_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .mem_cmd_valid(mem_cmd_valid),
    .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_write(mem_cmd_write),
    .mem_cmd_addr (mem_cmd_addr),
    .mem_cmd_len  (mem_cmd_len),
    .mem_wvalid   (mem_wvalid),
    .mem_wdata    (mem_wdata),
    .per_in_data  (per_in_data),
    .per_out_valid(per_out_valid),
    .swap_act     (swap_act),
    .done         (done)
);

// File: tb/sim_halfswap_dma_bridge.sv
`timescale 1ns/1ps
module sim_halfswap_dma_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_addr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_swap = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        mem_cmd_valid;
    logic        mem_cmd_ready = 1'b1;
    logic        mem_cmd_write;
    logic [31:0] mem_cmd_addr;
    logic [15:0] mem_cmd_len;
    logic        per_in_valid = 1'b0;
    logic        per_in_ready;
    logic [15:0] per_in_data = '0;
    logic        mem_wvalid;
    logic        mem_wready = 1'b1;
    logic [15:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic        mem_rready;
    logic [15:0] mem_rdata = '0;
    logic        per_out_valid;
    logic        per_out_ready = 1'b1;
    logic [15:0] per_out_data;
    logic        done;

    int checks = 0;
    int failures = 0;
    int stall_left = 0;
    int wd_cycles = 0;

    always #10 clk = ~clk;

    halfswap_dma_bridge u0 (.*);

    // Vector: {write, swap, addr, base, len, expected command count}
    localparam int NV = 10;
    localparam logic [89:0] VEC [NV] = '{
        {1'b1, 1'b0, 32'h1000_0013, 32'h0002_0000, 16'd7,   8'd1},
        {1'b0, 1'b0, 32'h0000_0101, 32'h0400_0000, 16'd5,   8'd1},
        {1'b1, 1'b1, 32'h0000_2001, 32'h8000_0000, 16'd11,  8'd1},
        {1'b0, 1'b1, 32'h0000_0303, 32'h0000_0010, 16'd9,   8'd1},
        {1'b1, 1'b1, 32'h0000_0100, 32'h0001_0000, 16'd150, 8'd3},
        {1'b0, 1'b1, 32'h0000_0100, 32'h0001_0000, 16'd150, 8'd1},
        {1'b1, 1'b1, 32'h0000_0040, 32'h0000_0000, 16'd1,   8'd0},
        {1'b1, 1'b0, 32'h0000_0041, 32'h0000_0000, 16'd0,   8'd0},
        {1'b1, 1'b1, 32'h0000_0201, 32'h0000_0000, 16'd129, 8'd2},
        {1'b1, 1'b0, 32'h0000_0005, 32'h0000_0000, 16'd150, 8'd1}
    };

    function automatic logic [15:0] pat(input int b);
        return 16'h5A3C + 16'(b) * 16'h0111;
    endfunction

    function automatic logic [15:0] bsw(input logic [15:0] x);
        return {x[7:0], x[15:8]};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Run one request with a responsive memory and peripheral; checks every
    // command, every data beat and the completion timing.
    task automatic run(input logic w, input logic s, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] l, input int ncmd);
        logic [31:0] cur;
        logic [15:0] rem;
        logic [15:0] explen;
        logic [15:0] expd;
        int beats = 0;
        int expbeats = 0;
        int cmds = 0;
        int last = -1;
        logic got = 1'b0;
        cur = (a | b) & (s ? 32'hFFFF_FFFE : 32'hFFFF_FFFF);
        rem = s ? (l & 16'hFFFE) : l;
        @(negedge clk);
        base_addr = b; req_write = w; req_swap = s; req_addr = a; req_len = l;
        req_valid = 1'b1;
        #1 chk(req_ready == 1'b1, "R10 ready when idle", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 600; cyc++) begin
            if (cyc > 0) @(negedge clk);
            mem_cmd_ready = (stall_left == 0);
            per_in_valid = 1'b1; mem_rvalid = 1'b1;
            per_in_data = pat(beats); mem_rdata = pat(beats);
            #1;
            if (mem_cmd_valid) begin
                explen = (w && s && rem > 16'd64) ? 16'd64 : rem;
                chk(mem_cmd_addr == cur, s ? "R2 cmd addr" : "R1 cmd addr",
                    mem_cmd_addr, cur);
                chk(mem_cmd_len == explen,
                    (w && s) ? "R6 cmd len" : (s ? "R2 cmd len" : "R7 cmd len"),
                    32'(mem_cmd_len), 32'(explen));
                chk(mem_cmd_write == w, "R7 cmd dir", 32'(mem_cmd_write), 32'(w));
                if (mem_cmd_ready) begin
                    cmds++; cur = cur + 32'(explen); rem = rem - explen;
                    expbeats += (int'(explen) + 1) / 2;
                end else begin
                    stall_left--;
                end
            end
            if (mem_wvalid && mem_wready) begin
                expd = s ? bsw(pat(beats)) : pat(beats);
                chk(mem_wdata == expd, s ? "R3 write data" : "R5 write data",
                    32'(mem_wdata), 32'(expd));
                beats++; last = cyc;
            end
            if (per_out_valid && per_out_ready) begin
                expd = s ? bsw(pat(beats)) : pat(beats);
                chk(per_out_data == expd, s ? "R4 read data" : "R5 read data",
                    32'(per_out_data), 32'(expd));
                beats++; last = cyc;
            end
            if (done) begin
                got = 1'b1;
                chk(cmds == ncmd, (ncmd == 0) ? "R8 command count" : "R6 command count",
                    32'(cmds), 32'(ncmd));
                chk(beats == expbeats, "R5 beat count", 32'(beats), 32'(expbeats));
                chk(rem == 16'd0, "R6 bytes left", 32'(rem), 32'd0);
                chk(cyc == last + 1, (ncmd == 0) ? "R8 done timing" : "R9 done timing",
                    32'(cyc), 32'(last + 1));
                break;
            end
        end
        chk(got, "R9 done seen", 32'(got), 32'd1);
        @(negedge clk);
        #1 chk(done == 1'b0, "R9 done single", 32'(done), 32'd0);
        per_in_valid = 1'b0; mem_rvalid = 1'b0; mem_cmd_ready = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        wd_cycles++;
        if (wd_cycles > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<100000", wd_cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready == 1'b1, "R10 reset ready", 32'(req_ready), 32'd1);
        chk(mem_cmd_valid == 1'b0, "R10 reset cmd", 32'(mem_cmd_valid), 32'd0);
        chk(done == 1'b0, "R10 reset done", 32'(done), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run(VEC[i][89], VEC[i][88], VEC[i][87:56], VEC[i][55:24],
                VEC[i][23:8], int'(VEC[i][7:0]));
        end

        // R11: command stalled for three cycles, then the chunked write proceeds.
        stall_left = 3;
        run(1'b1, 1'b1, 32'h0000_0100, 32'h0001_0000, 16'd150, 3);
        chk(stall_left == 0, "R11 stall consumed", 32'(stall_left), 32'd0);

        // R10: reset in the middle of a data phase returns to idle.
        @(negedge clk);
        req_write = 1'b1; req_swap = 1'b1; req_addr = 32'h80; req_len = 16'd100;
        base_addr = '0; req_valid = 1'b1; per_in_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk(req_ready == 1'b1, "R10 mid reset ready", 32'(req_ready), 32'd1);
        chk(mem_wvalid == 1'b0, "R10 mid reset wvalid", 32'(mem_wvalid), 32'd0);
        chk(mem_cmd_valid == 1'b0, "R10 mid reset cmd", 32'(mem_cmd_valid), 32'd0);
        per_in_valid = 1'b0;
        rst_n = 1'b1;
        run(1'b0, 1'b0, 32'h0000_0007, 32'h0000_0100, 16'd3, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule